// File: doc/BRIEF.md
# Supply Sequencing Controller with Timed Hold and Drain

This controller drives the enable of the IO-ring supply of a programmable logic device and the release of the system reset. It compares the enable against a power-request level from the processor. A rising request turns the IO ring on with no deliberate wait; only the synchronizer latency applies. A falling request starts a drain interval, 10 ms by default, before the ring is switched off. The processor turns the core supply off elsewhere during that interval, so the core always goes down before the IO ring.

A cold-boot reset input starts a separate path. The controller keeps the system reset asserted and the IO ring off for a hold interval, 100 ms by default. When the hold ends, it releases the reset and enables the ring on the same clock edge. All intervals are counted by a millisecond prescaler whose length in clock cycles is a parameter. This lets a simulation use a short millisecond. The current sequencing phase is brought out as a two-bit status code.

Top module: `supply_seq_ctrl`

## Requirements
- R1: While `porN` is low, `ioSupplyEn` is 0, `sysResetN` is 0 and `seqState` is 2'b00.
- R2: After `porN` rises, `sysResetN` and `ioSupplyEn` stay 0 and `seqState` stays 2'b00 for COLD_HOLD_MS*CYCLES_PER_MS clock cycles.
- R3: On the first clock edge after the hold interval ends, `sysResetN` and `ioSupplyEn` both go to 1 and `seqState` becomes 2'b01. This happens whatever the level of `cpuPwrEn`.
- R4: Changes on `cpuPwrEn` during the hold interval neither shorten nor extend it.
- R5: With `sysResetN` high, a rise of `cpuPwrEn` that is held sets `ioSupplyEn` to 1 no more than SYNC_STAGES+1 cycles later. No timed wait applies.
- R6: After `cpuPwrEn` falls and stays low, `ioSupplyEn` stays 1 for OFF_DELAY_MS*CYCLES_PER_MS cycles after the drain phase is entered. It goes to 0 on the next edge.
- R7: If `cpuPwrEn` returns high during the drain phase, `ioSupplyEn` stays 1 and the status goes back to 2'b01. A later fall starts a full new drain interval.
- R8: The status encoding is 2'b00 cold hold, 2'b01 on, 2'b10 draining and 2'b11 off.
- R9: `cpuPwrEn` passes through a SYNC_STAGES flop synchronizer. The first state change follows a fall of `cpuPwrEn` by SYNC_STAGES+1 edges.
- R10: Once released, `sysResetN` stays 1 until `porN` goes low again.
- R11: A low on `porN` in any phase forces the cold-hold state at once, and the full hold interval restarts on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| porN | input | 1 | Cold-boot reset, active low, asynchronous assert |
| cpuPwrEn | input | 1 | Processor power request, 1 = run, 0 = suspend |
| ioSupplyEn | output | 1 | IO-ring supply enable |
| sysResetN | output | 1 | System reset, active low |
| seqState | output | 2 | Sequencing phase code (see R8) |

## Verification
The checker asserts the following on every cycle:
- the reset never re-asserts once released;
- the IO ring is never on while reset is held;
- the release never comes before the hold length counted from the cold-boot reset;
- the ring never drops unless the request has been low for at least the drain length;
- a request that has been high for three cycles always finds the ring enabled.

Only the bench scenarios can show the exact edges of these events. They cover the hold end, the drain end and the synchronizer latency. They also cover the cancel-and-restart of the drain, the indifference to request toggles during the hold, and a warm cold-boot in the middle of operation.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

  // Phase codes; the encoding is visible on the status port.
  typedef enum logic [1:0] {
    ST_COLD  = 2'b00,
    ST_ON    = 2'b01,
    ST_DRAIN = 2'b10,
    ST_OFF   = 2'b11
  } seqState_e;

  // Strobes from the control FSM to the interval timer.
  typedef struct packed {
    logic clear;
    logic run;
  } timerCtrl_t;

  // Comparator results from the timer back to the FSM.
  typedef struct packed {
    logic holdDone;
    logic drainDone;
  } timerFlags_t;

endpackage

// File: rtl/supply_seq_sync.sv
module supply_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/supply_seq_timer.sv
module supply_seq_timer
  import supply_seq_pkg::*;
#(
  parameter int CYCLES_PER_MS = 125000,
  parameter int OFF_DELAY_MS  = 10,
  parameter int COLD_HOLD_MS  = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  timerCtrl_t  ctrl,
  output timerFlags_t flags
);

  localparam int PRE_W  = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam int MS_MAX = (COLD_HOLD_MS > OFF_DELAY_MS) ? COLD_HOLD_MS : OFF_DELAY_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(CYCLES_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_TOP    = MS_W'(MS_MAX);
  localparam logic [MS_W-1:0]  HOLD_MS_V = MS_W'(COLD_HOLD_MS);
  localparam logic [MS_W-1:0]  OFF_MS_V  = MS_W'(OFF_DELAY_MS);

  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msCnt;
  logic             msTick;

  assign msTick = ctrl.run && (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctrl.clear) begin
      preCnt <= '0;
    end else if (ctrl.run) begin
      preCnt <= msTick ? '0 : preCnt + 1'b1;
    end
  end

  // Elapsed milliseconds, saturating at the longest interval.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt <= '0;
    end else if (ctrl.clear) begin
      msCnt <= '0;
    end else if (msTick && (msCnt != MS_TOP)) begin
      msCnt <= msCnt + 1'b1;
    end
  end

  assign flags.holdDone  = (msCnt == HOLD_MS_V);
  assign flags.drainDone = (msCnt == OFF_MS_V);

endmodule

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
  import supply_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrOk,
  input  timerFlags_t flags,
  output timerCtrl_t  ctrl,
  output seqState_e   state,
  output logic        ioEnQ,
  output logic        rstRelQ
);

  seqState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_COLD:  if (flags.holdDone) nextState = ST_ON;
      ST_ON:    if (!pwrOk) nextState = ST_DRAIN;
      ST_DRAIN: begin
        if (pwrOk)                nextState = ST_ON;
        else if (flags.drainDone) nextState = ST_OFF;
      end
      ST_OFF:   if (pwrOk) nextState = ST_ON;
      default:  nextState = ST_COLD;
    endcase
  end

  // Restart the timer on entry to the drain phase; count only while timing.
  always_comb begin
    ctrl.clear = (state == ST_ON) && !pwrOk;
    ctrl.run   = (state == ST_COLD) || (state == ST_DRAIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_COLD;
      ioEnQ   <= 1'b0;
      rstRelQ <= 1'b0;
    end else begin
      state   <= nextState;
      ioEnQ   <= (nextState == ST_ON) || (nextState == ST_DRAIN);
      rstRelQ <= (nextState != ST_COLD);
    end
  end

endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
  import supply_seq_pkg::*;
#(
  parameter int CYCLES_PER_MS = 125000,
  parameter int OFF_DELAY_MS  = 10,
  parameter int COLD_HOLD_MS  = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       cpuPwrEn,
  output logic       ioSupplyEn,
  output logic       sysResetN,
  output logic [1:0] seqState
);

  logic        pwrOk;
  timerCtrl_t  tCtrl;
  timerFlags_t tFlags;
  seqState_e   curState;

  supply_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (porN),
    .din  (cpuPwrEn),
    .dout (pwrOk)
  );

  supply_seq_timer #(
    .CYCLES_PER_MS (CYCLES_PER_MS),
    .OFF_DELAY_MS  (OFF_DELAY_MS),
    .COLD_HOLD_MS  (COLD_HOLD_MS)
  ) u_timer (
    .clk   (clk),
    .rstN  (porN),
    .ctrl  (tCtrl),
    .flags (tFlags)
  );

  supply_seq_fsm u_fsm (
    .clk     (clk),
    .rstN    (porN),
    .pwrOk   (pwrOk),
    .flags   (tFlags),
    .ctrl    (tCtrl),
    .state   (curState),
    .ioEnQ   (ioSupplyEn),
    .rstRelQ (sysResetN)
  );

  assign seqState = curState;

endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk #(
  parameter int CYCLES_PER_MS = 125000,
  parameter int OFF_DELAY_MS  = 10,
  parameter int COLD_HOLD_MS  = 100,
  parameter int SYNC_STAGES   = 2
) (
  input logic       clk,
  input logic       porN,
  input logic       cpuPwrEn,
  input logic       ioSupplyEn,
  input logic       sysResetN,
  input logic [1:0] seqState
);

  localparam logic [31:0] HOLD_CYC  = 32'(COLD_HOLD_MS * CYCLES_PER_MS);
  localparam logic [31:0] DRAIN_CYC = 32'(OFF_DELAY_MS * CYCLES_PER_MS);
  localparam logic [31:0] ON_LAT    = 32'(SYNC_STAGES + 1);
  localparam logic [31:0] SAT       = 32'hFFFF_FFFF;

  logic [31:0] sincePor, lowRun, highRun;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sincePor <= '0;
      lowRun   <= '0;
      highRun  <= '0;
    end else begin
      if (sincePor != SAT) sincePor <= sincePor + 1;
      lowRun  <= cpuPwrEn ? '0 : ((lowRun != SAT) ? lowRun + 1 : lowRun);
      highRun <= !cpuPwrEn ? '0 : ((highRun != SAT) ? highRun + 1 : highRun);
    end
  end

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysResetN) |-> (sincePor >= HOLD_CYC));

  // R10
  rst_stay_chk: assert property (@(posedge clk) disable iff (!porN)
    sysResetN |=> sysResetN);

  // R3
  joint_release_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysResetN) |-> ioSupplyEn);

  // R1
  ring_off_in_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    !sysResetN |-> (!ioSupplyEn && seqState == 2'b00));

  // R6
  drain_len_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(ioSupplyEn) |-> (lowRun >= DRAIN_CYC));

  // R5
  fast_on_chk: assert property (@(posedge clk) disable iff (!porN)
    (sysResetN && highRun >= ON_LAT) |-> ioSupplyEn);

endmodule

bind supply_seq_ctrl supply_seq_chk #(
  .CYCLES_PER_MS (CYCLES_PER_MS),
  .OFF_DELAY_MS  (OFF_DELAY_MS),
  .COLD_HOLD_MS  (COLD_HOLD_MS),
  .SYNC_STAGES   (SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .porN       (porN),
  .cpuPwrEn   (cpuPwrEn),
  .ioSupplyEn (ioSupplyEn),
  .sysResetN  (sysResetN),
  .seqState   (seqState)
);

// File: tb/sim_supply_seq_ctrl.sv
module sim_supply_seq_ctrl;

  localparam int CPM  = 4;
  localparam int OFFM = 10;
  localparam int HLDM = 100;
  localparam int H    = CPM * HLDM;  // hold cycles
  localparam int O    = CPM * OFFM;  // drain cycles

  typedef struct {
    int         at;
    logic       en;
    logic       rst;
    logic [1:0] st;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       porN = 1'b1;
  logic       cpuPwrEn = 1'b0;
  logic       ioSupplyEn, sysResetN;
  logic [1:0] seqState;

  int    cyc = 0;
  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc++;

  supply_seq_ctrl #(
    .CYCLES_PER_MS (CPM),
    .OFF_DELAY_MS  (OFFM),
    .COLD_HOLD_MS  (HLDM),
    .SYNC_STAGES   (2)
  ) u0 (
    .clk        (clk),
    .porN       (porN),
    .cpuPwrEn   (cpuPwrEn),
    .ioSupplyEn (ioSupplyEn),
    .sysResetN  (sysResetN),
    .seqState   (seqState)
  );

  // Driver side: queue an expected output set for a future cycle.
  task automatic expectAt(input int at, input logic en, input logic rst,
                          input logic [1:0] st, input string tag);
    item_t it;
    it.at = at; it.en = en; it.rst = rst; it.st = st; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor side: compare queued items when their cycle comes up.
  always @(negedge clk) begin
    while (sb.size() != 0 && sb[0].at <= cyc) begin
      item_t it;
      it = sb.pop_front();
      nRun++;
      if (it.at < cyc) begin
        nFail++;
        $display("FAIL %s: check for cycle %0d missed (now %0d)", it.tag, it.at, cyc);
      end else if (ioSupplyEn !== it.en || sysResetN !== it.rst || seqState !== it.st) begin
        nFail++;
        $display("FAIL %s cyc=%0d: got en=%b rstN=%b st=%b, expected en=%b rstN=%b st=%b",
                 it.tag, cyc, ioSupplyEn, sysResetN, seqState, it.en, it.rst, it.st);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, got hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : stim
    int c0, d, u, p;
    #1 porN = 1'b0;
    // R1: reset state while porN is low
    expectAt(1, 1'b0, 1'b0, 2'b00, "R1");
    expectAt(2, 1'b0, 1'b0, 2'b00, "R1");
    waitCyc(3);
    c0 = cyc;
    porN = 1'b1;
    // R2 / R3 / R4: hold length, joint release, request toggles ignored
    expectAt(c0 + H,      1'b0, 1'b0, 2'b00, "R2");
    expectAt(c0 + H + 1,  1'b1, 1'b1, 2'b01, "R3");
    expectAt(c0 + H + 10, 1'b1, 1'b1, 2'b01, "R4");
    waitCyc(c0 + 10);  cpuPwrEn = 1'b1;
    waitCyc(c0 + 50);  cpuPwrEn = 1'b0;
    waitCyc(c0 + 100); cpuPwrEn = 1'b1;
    drain();

    // R6 / R8 / R9: delayed turn-off
    d = cyc + 2;
    waitCyc(d);
    cpuPwrEn = 1'b0;
    expectAt(d + 2,     1'b1, 1'b1, 2'b01, "R9");
    expectAt(d + 3,     1'b1, 1'b1, 2'b10, "R8");
    expectAt(d + 3 + O, 1'b1, 1'b1, 2'b10, "R6");
    expectAt(d + 4 + O, 1'b0, 1'b1, 2'b11, "R6");
    drain();

    // R5: immediate turn-on
    u = cyc + 3;
    waitCyc(u);
    cpuPwrEn = 1'b1;
    expectAt(u + 2, 1'b0, 1'b1, 2'b11, "R5");
    expectAt(u + 3, 1'b1, 1'b1, 2'b01, "R5");
    drain();

    // R7: cancel during drain, then a full restart
    d = cyc + 2;
    waitCyc(d);
    cpuPwrEn = 1'b0;
    expectAt(d + 12,         1'b1, 1'b1, 2'b10, "R7");
    expectAt(d + 13,         1'b1, 1'b1, 2'b01, "R7");
    expectAt(d + 13 + O + 5, 1'b1, 1'b1, 2'b01, "R7");
    waitCyc(d + 10);
    cpuPwrEn = 1'b1;
    drain();
    d = cyc + 2;
    waitCyc(d);
    cpuPwrEn = 1'b0;
    expectAt(d + 3 + O, 1'b1, 1'b1, 2'b10, "R7");
    expectAt(d + 4 + O, 1'b0, 1'b1, 2'b11, "R7");
    drain();

    // R11: warm cold-boot while on, then release with request low
    waitCyc(cyc + 3);
    cpuPwrEn = 1'b1;
    waitCyc(cyc + 6);
    p = cyc;
    porN = 1'b0;
    cpuPwrEn = 1'b0;
    expectAt(p + 1, 1'b0, 1'b0, 2'b00, "R11");
    waitCyc(p + 2);
    porN = 1'b1;
    expectAt(p + 2 + H,         1'b0, 1'b0, 2'b00, "R11");
    expectAt(p + 3 + H,         1'b1, 1'b1, 2'b01, "R3");
    expectAt(p + 4 + H,         1'b1, 1'b1, 2'b10, "R8");
    expectAt(p + 4 + H + O,     1'b1, 1'b1, 2'b10, "R6");
    expectAt(p + 5 + H + O,     1'b0, 1'b1, 2'b11, "R10");
    expectAt(p + 5 + H + O + 8, 1'b0, 1'b1, 2'b11, "R10");
    drain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule